// File: doc/BRIEF.md
# Direct-Store I/O Transaction Sequencer

This block takes one program-level load or store and carries it out on a simplified system bus. A request whose segment type bit is set is a direct-store (I/O) access. The block cuts it into single-beat tenures, each with its own two-packet address phase and its own data phase. It then stalls the requester until the bus unit controller sends back a completion reply carrying the matching tag, and reports the error or no-error status for that request alone. A request whose type bit is clear is an ordinary memory-mapped access. It runs as one address tenure under the normal start strobe and one data beat, and needs no reply.

Requests arrive on a valid/ready channel and are taken one at a time, so I/O accesses reach the bus strictly in program order. Store data enters as a valid/ready stream with one word per data beat. Load data leaves as a valid/ready stream with one word per beat. Either stream may be held off by its consumer. A word offered on the load stream stays stable until it is taken. A store word is consumed only in the cycle the bus acknowledges the data beat. Each bus phase is held until the bus acknowledges it. Completion appears as a one-cycle `done` pulse, with `err` beside it.

Top module: `dsio_seq`

## Requirements
- R1: With `req_io`=0 the block makes one address beat, with `bus_ts`=1, `bus_xts`=0 and `bus_addr`=`req_addr`. It follows this with one data beat and then pulses `done` with `err`=0, without waiting for a reply. `bus_op` is {0, write, 0, byte count[2:0]}.
- R2: A direct-store request may move 1 to 128 bytes. While a transfer is under way, the remaining byte count is never 0 and never exceeds 128.
- R3: Data moves in beats of up to 4 bytes. Request length L gives ceil(L/4) beats, and beat k of packet 1 carries address `req_addr`+4k. Lanes are filled from bit 0 upward: `bus_be`/`ld_be` is 4'hF when 4 or more bytes remain, and otherwise (1<<remaining)-1.
- R4: Each direct-store beat presents packet 0 (`bus_apkt`=0, `bus_xts`=1) and then packet 1 (`bus_apkt`=1, no strobe). Each packet is held stable until `bus_aack`. Packet 0 is {seg[23:12], tag[3:0], remaining bytes[7:0], write, 7'b0}. Packet 1 is {seg[11:0], beat address[19:0]}.
- R5: On direct-store beats, `bus_op` is the I/O opcode {1, write, last beat, 3'b000}.
- R6: `req_ready` is high only while idle. No request is taken before the previous one has finished, and no bus activity occurs while idle.
- R7: After the last direct-store beat, `done` stays low until a reply with the matching tag arrives. The block then pulses `done` for one cycle.
- R8: In the data phase of a store, `bus_dten` follows `sd_valid` and `bus_wdata` equals `sd_data`. `sd_ready` is high only when `bus_dack` acknowledges that beat.
- R9: After each load beat, `ld_valid` is raised with the captured word and its lane enables. These are held stable until `ld_ready`.
- R10: A reply whose tag differs from the current sender tag is ignored. The block keeps waiting and `done` stays low.
- R11: `err` equals the error bit of the matching reply and appears in the same cycle as `done`. The block then returns to idle with no retry.
- R12: A request of length 0, of length over 128, or of a memory-mapped access longer than 4 bytes is taken and answered in the next cycle with `done`=1 and `err`=1. No bus activity occurs.
- R13: The sender tag is 0 after reset. It advances by one, modulo 16, each time a direct-store request completes through a reply. Rejected requests do not advance it.
- R14: After reset, `req_ready`=1 and every strobe, `bus_av`, `bus_dten`, `ld_valid`, `done` and `err` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request taken (idle only) |
| req_io | input | 1 | Segment type bit: 1 = direct-store |
| req_write | input | 1 | 1 = store, 0 = load |
| req_seg | input | 24 | Segment descriptor bits |
| req_addr | input | 32 | Logical address |
| req_len | input | 8 | Byte count |
| sd_valid | input | 1 | Store word offered |
| sd_ready | output | 1 | Store word consumed |
| sd_data | input | 32 | Store word |
| ld_valid | output | 1 | Load word offered |
| ld_ready | input | 1 | Load word taken |
| ld_data | output | 32 | Load word |
| ld_be | output | 4 | Valid lanes of the load word |
| bus_ts | output | 1 | Memory-mapped start strobe |
| bus_xts | output | 1 | Direct-store start strobe |
| bus_av | output | 1 | Address beat valid |
| bus_apkt | output | 1 | Address packet index |
| bus_addr | output | 32 | Address beat contents |
| bus_op | output | 6 | Transfer opcode |
| bus_aack | input | 1 | Address beat acknowledge |
| bus_dten | output | 1 | Data tenure active |
| bus_be | output | 4 | Data lane enables |
| bus_wdata | output | 32 | Store data to bus |
| bus_rdata | input | 32 | Load data from bus |
| bus_dack | input | 1 | Data beat acknowledge |
| rep_valid | input | 1 | Reply transaction present |
| rep_tag | input | 4 | Reply tag |
| rep_err | input | 1 | Reply error status |
| done | output | 1 | Request finished (one cycle) |
| err | output | 1 | Error status, valid with done |

## Verification
The assertions check the following on every cycle: the two start strobes are never high together, nothing moves on the bus while idle, address beats and load words are held until acknowledged, the byte counter stays within bounds during a transfer, `err` never appears without `done`, and a bad length is answered in the next cycle. The bench's scenarios are needed for everything that depends on a whole request. That covers the beat count and lane enables derived from the length, the contents of the two packets beat by beat, the tag sequence across requests, the skipping of foreign-tag replies, and the correct error status reaching the requester.

// File: rtl/dsio_pkg.sv
package dsio_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR0,
    ST_ADDR1,
    ST_DATA,
    ST_NEXT,
    ST_WAIT
  } dsio_state_e;
endpackage

// File: rtl/dsio_lane_calc.sv
// Derives lane enables, byte count and last-beat flag from the bytes remaining.
module dsio_lane_calc #(
  parameter int BEAT_BYTES = 4,
  parameter int CNT_W      = 8,
  localparam int NB_W      = $clog2(BEAT_BYTES + 1)
) (
  input  logic [CNT_W-1:0]      rem,
  output logic [BEAT_BYTES-1:0] be,
  output logic [NB_W-1:0]       nb,
  output logic                  last
);
  for (genvar i = 0; i < BEAT_BYTES; i++) begin : g_lane
    assign be[i] = (rem > CNT_W'(i));
  end

  always_comb begin
    if (rem >= CNT_W'(BEAT_BYTES)) nb = NB_W'(BEAT_BYTES);
    else                           nb = rem[NB_W-1:0];
    last = (rem <= CNT_W'(BEAT_BYTES));
  end
endmodule

// File: rtl/dsio_pkt_build.sv
// Forms the address beat word: a plain address for memory-mapped accesses, or one of two packets.
module dsio_pkt_build #(
  parameter int ADDR_W = 32,
  parameter int SEG_W  = 24,
  parameter int TAG_W  = 4,
  parameter int CNT_W  = 8,
  localparam int SEG_HI_W = SEG_W / 2,
  localparam int SEG_LO_W = SEG_W - SEG_HI_W,
  localparam int LOW_W    = ADDR_W - SEG_LO_W,
  localparam int PAD_W    = ADDR_W - SEG_HI_W - TAG_W - CNT_W - 1
) (
  input  logic              io,
  input  logic              pkt_sel,
  input  logic [SEG_W-1:0]  seg,
  input  logic [TAG_W-1:0]  tag,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] word
);
  logic [ADDR_W-1:0] pkt0, pkt1;

  assign pkt0 = {seg[SEG_W-1 -: SEG_HI_W], tag, cnt, wr, {PAD_W{1'b0}}};
  assign pkt1 = {seg[SEG_LO_W-1:0], addr[LOW_W-1:0]};

  always_comb begin
    if (!io)         word = addr;
    else if (pkt_sel) word = pkt1;
    else             word = pkt0;
  end
endmodule

// File: rtl/dsio_reply_filter.sv
// Accepts a reply only while waiting and only with the current sender tag.
module dsio_reply_filter #(
  parameter int TAG_W = 4
) (
  input  logic             armed,
  input  logic             rep_valid,
  input  logic [TAG_W-1:0] rep_tag,
  input  logic [TAG_W-1:0] cur_tag,
  output logic             hit
);
  assign hit = armed && rep_valid && (rep_tag == cur_tag);
endmodule

// File: rtl/dsio_seq.sv
module dsio_seq
  import dsio_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int SEG_W      = 24,
  parameter int TAG_W      = 4,
  parameter int MAX_BYTES  = 128,
  parameter int BEAT_BYTES = 4,
  localparam int CNT_W     = $clog2(MAX_BYTES + 1),
  localparam int DATA_W    = 8 * BEAT_BYTES,
  localparam int NB_W      = $clog2(BEAT_BYTES + 1),
  localparam int OP_W      = 3 + NB_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_io,
  input  logic              req_write,
  input  logic [SEG_W-1:0]  req_seg,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CNT_W-1:0]  req_len,
  input  logic              sd_valid,
  output logic              sd_ready,
  input  logic [DATA_W-1:0] sd_data,
  output logic              ld_valid,
  input  logic              ld_ready,
  output logic [DATA_W-1:0] ld_data,
  output logic [BEAT_BYTES-1:0] ld_be,
  output logic              bus_ts,
  output logic              bus_xts,
  output logic              bus_av,
  output logic              bus_apkt,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [OP_W-1:0]   bus_op,
  input  logic              bus_aack,
  output logic              bus_dten,
  output logic [BEAT_BYTES-1:0] bus_be,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_dack,
  input  logic              rep_valid,
  input  logic [TAG_W-1:0]  rep_tag,
  input  logic              rep_err,
  output logic              done,
  output logic              err
);
  dsio_state_e       st;
  logic              io_q, wr_q;
  logic [SEG_W-1:0]  seg_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [TAG_W-1:0]  tag_q;
  logic [DATA_W-1:0] rdata_q;
  logic              done_q, err_q;

  logic [BEAT_BYTES-1:0] lane_be;
  logic [NB_W-1:0]       lane_nb;
  logic                  lane_last;
  logic [ADDR_W-1:0]     pkt_word;
  logic                  rep_hit;
  logic                  req_bad;
  logic                  xfer;

  dsio_lane_calc #(.BEAT_BYTES(BEAT_BYTES), .CNT_W(CNT_W)) u_lane (
    .rem(cnt_q), .be(lane_be), .nb(lane_nb), .last(lane_last)
  );

  dsio_pkt_build #(.ADDR_W(ADDR_W), .SEG_W(SEG_W), .TAG_W(TAG_W), .CNT_W(CNT_W)) u_pkt (
    .io(io_q), .pkt_sel(st == ST_ADDR1), .seg(seg_q), .tag(tag_q), .cnt(cnt_q),
    .wr(wr_q), .addr(addr_q), .word(pkt_word)
  );

  dsio_reply_filter #(.TAG_W(TAG_W)) u_rep (
    .armed(st == ST_WAIT), .rep_valid(rep_valid), .rep_tag(rep_tag),
    .cur_tag(tag_q), .hit(rep_hit)
  );

  assign req_bad = (req_len == '0) || (req_len > CNT_W'(MAX_BYTES)) ||
                   (!req_io && (req_len > CNT_W'(BEAT_BYTES)));

  // Bus-side decode
  assign req_ready = (st == ST_IDLE);
  assign bus_av    = (st == ST_ADDR0) || (st == ST_ADDR1);
  assign bus_apkt  = (st == ST_ADDR1);
  assign bus_ts    = (st == ST_ADDR0) && !io_q;
  assign bus_xts   = (st == ST_ADDR0) && io_q;
  assign bus_addr  = bus_av ? pkt_word : '0;
  assign bus_dten  = (st == ST_DATA) && (wr_q ? sd_valid : 1'b1);
  assign bus_be    = (st == ST_DATA) ? lane_be : '0;
  assign bus_wdata = ((st == ST_DATA) && wr_q) ? sd_data : '0;
  assign xfer      = bus_dten && bus_dack;
  assign sd_ready  = (st == ST_DATA) && wr_q && bus_dack;
  assign ld_valid  = (st == ST_NEXT) && !wr_q;
  assign ld_data   = rdata_q;
  assign ld_be     = ld_valid ? lane_be : '0;
  assign done      = done_q;
  assign err       = err_q;

  always_comb begin
    if (st == ST_IDLE)  bus_op = '0;
    else if (io_q)      bus_op = {1'b1, wr_q, lane_last, {NB_W{1'b0}}};
    else                bus_op = {1'b0, wr_q, 1'b0, lane_nb};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      io_q    <= 1'b0;
      wr_q    <= 1'b0;
      seg_q   <= '0;
      addr_q  <= '0;
      cnt_q   <= '0;
      tag_q   <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (req_valid) begin
            if (req_bad) begin
              done_q <= 1'b1;
              err_q  <= 1'b1;
            end else begin
              io_q   <= req_io;
              wr_q   <= req_write;
              seg_q  <= req_seg;
              addr_q <= req_addr;
              cnt_q  <= req_len;
              st     <= ST_ADDR0;
            end
          end
        end
        ST_ADDR0: if (bus_aack) st <= io_q ? ST_ADDR1 : ST_DATA;
        ST_ADDR1: if (bus_aack) st <= ST_DATA;
        ST_DATA: begin
          if (xfer) begin
            if (!wr_q) rdata_q <= bus_rdata;
            st <= ST_NEXT;
          end
        end
        ST_NEXT: begin
          if (wr_q || ld_ready) begin
            cnt_q  <= cnt_q - CNT_W'(lane_nb);
            addr_q <= addr_q + ADDR_W'(BEAT_BYTES);
            if (!io_q) begin
              done_q <= 1'b1;
              st     <= ST_IDLE;
            end else if (lane_last) begin
              st <= ST_WAIT;
            end else begin
              st <= ST_ADDR0;
            end
          end
        end
        ST_WAIT: begin
          if (rep_hit) begin
            done_q <= 1'b1;
            err_q  <= rep_err;
            tag_q  <= tag_q + TAG_W'(1);
            st     <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // Assertions
  p_strobe_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_ts && bus_xts));

  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_IDLE && st != ST_WAIT) |-> (cnt_q != '0 && cnt_q <= CNT_W'(MAX_BYTES)));

  p_addr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_av && !bus_aack) |=> (bus_av && $stable(bus_addr) && $stable(bus_apkt)));

  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !(bus_av || bus_dten || ld_valid));

  p_wait_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT && !rep_valid) |=> !done);

  p_ld_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && !ld_ready) |=> (ld_valid && $stable(ld_data) && $stable(ld_be)));

  p_err_with_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);

  p_reject_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (req_len == '0 || req_len > CNT_W'(MAX_BYTES)))
      |=> (done && err && !bus_av));
endmodule

// File: tb/dsio_seq_test.sv
`timescale 1ns/1ps
module dsio_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 0, req_io = 0, req_write = 0;
  logic        req_ready;
  logic [23:0] req_seg = '0;
  logic [31:0] req_addr = '0;
  logic [7:0]  req_len = '0;
  logic        sd_valid = 0, sd_ready;
  logic [31:0] sd_data = '0;
  logic        ld_valid, ld_ready = 0;
  logic [31:0] ld_data;
  logic [3:0]  ld_be;
  logic        bus_ts, bus_xts, bus_av, bus_apkt, bus_dten;
  logic [31:0] bus_addr, bus_wdata;
  logic [31:0] bus_rdata = '0;
  logic [5:0]  bus_op;
  logic        bus_aack = 0, bus_dack = 0;
  logic [3:0]  bus_be;
  logic        rep_valid = 0, rep_err = 0;
  logic [3:0]  rep_tag = '0;
  logic        done, err;

  int n_chk = 0;
  int n_fail = 0;
  logic [3:0] exp_tag = '0;

  always #2 clk = ~clk;

  dsio_seq uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_io(req_io), .req_write(req_write),
    .req_seg(req_seg), .req_addr(req_addr), .req_len(req_len),
    .sd_valid(sd_valid), .sd_ready(sd_ready), .sd_data(sd_data),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_data(ld_data), .ld_be(ld_be),
    .bus_ts(bus_ts), .bus_xts(bus_xts), .bus_av(bus_av), .bus_apkt(bus_apkt),
    .bus_addr(bus_addr), .bus_op(bus_op), .bus_aack(bus_aack),
    .bus_dten(bus_dten), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_dack(bus_dack),
    .rep_valid(rep_valid), .rep_tag(rep_tag), .rep_err(rep_err),
    .done(done), .err(err)
  );

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [3:0] f_be(input int rem);
    logic [3:0] b;
    for (int i = 0; i < 4; i++) b[i] = (rem > i);
    return b;
  endfunction

  function automatic int f_nb(input int rem);
    return (rem >= 4) ? 4 : rem;
  endfunction

  function automatic logic [31:0] f_pkt0(input logic [23:0] seg, input logic [3:0] tag,
                                         input int rem, input bit wr);
    return {seg[23:12], tag, 8'(rem), wr, 7'b0};
  endfunction

  function automatic logic [31:0] f_pkt1(input logic [23:0] seg, input logic [31:0] a);
    return {seg[11:0], a[19:0]};
  endfunction

  function automatic logic [5:0] f_op(input bit io, input bit wr, input int rem);
    if (io) return {1'b1, wr, (rem <= 4), 3'b000};
    return {1'b0, wr, 1'b0, 3'(f_nb(rem))};
  endfunction

  // One address packet; ends at the negedge after the acknowledge.
  task automatic addr_phase(input bit pkt, input logic [31:0] ea, input bit ets, input bit exts,
                            input logic [5:0] eop, input string rq);
    bit go;
    forever begin
      chk(bus_av && bus_apkt == pkt, "R4 beat valid/index", {bus_av, bus_apkt}, {1'b1, pkt});
      chk(bus_addr == ea, rq, bus_addr, ea);
      chk(bus_ts == ets && bus_xts == exts, "R1 strobe select", {bus_ts, bus_xts}, {ets, exts});
      chk(bus_op == eop, "R5 opcode", bus_op, eop);
      chk(!req_ready, "R6 busy", req_ready, 0);
      go = ($urandom_range(0, 2) != 0);
      bus_aack = go;
      @(negedge clk);
      bus_aack = 0;
      if (go) break;
    end
  endtask

  // One data beat plus its load handoff; ends at the negedge of the following state.
  task automatic data_phase(input bit wr, input logic [3:0] ebe);
    bit a, b;
    logic [31:0] w;
    w = $urandom;
    forever begin
      chk(bus_be == ebe, "R3 lane enables", bus_be, ebe);
      a = wr ? ($urandom_range(0, 1) == 1) : 1'b1;
      b = ($urandom_range(0, 2) != 0);
      if (wr) begin sd_valid = a; sd_data = w; end
      else bus_rdata = w;
      bus_dack = b;
      #1;
      chk(bus_dten == a, wr ? "R8 tenure follows store data" : "R9 load tenure", bus_dten, a);
      if (wr) begin
        chk(sd_ready == b, "R8 store consume", sd_ready, b);
        if (a) chk(bus_wdata == w, "R8 store data", bus_wdata, w);
      end
      @(negedge clk);
      sd_valid = 0; bus_dack = 0;
      if (a && b) break;
    end
    if (wr) @(negedge clk);
    else begin
      forever begin
        chk(ld_valid && ld_data == w && ld_be == ebe, "R9 load word",
            {ld_valid, ld_be, ld_data}, {1'b1, ebe, w});
        a = ($urandom_range(0, 2) != 0);
        ld_ready = a;
        @(negedge clk);
        ld_ready = 0;
        if (a) break;
      end
    end
  endtask

  task automatic do_req(input bit io, input bit wr, input logic [23:0] seg, input logic [31:0] addr,
                        input int len, input bit rerr, input int nbad);
    bit bad;
    int rem, k;
    logic [3:0] wt;
    bad = (len == 0) || (len > 128) || (!io && len > 4);
    req_valid = 1; req_io = io; req_write = wr; req_seg = seg; req_addr = addr; req_len = 8'(len);
    chk(req_ready, "R6 ready when idle", req_ready, 1);
    @(negedge clk);
    req_valid = 0;
    if (bad) begin
      chk(done && err, "R12 reject status", {done, err}, 2'b11);
      chk(!bus_av && !bus_dten && !bus_ts && !bus_xts, "R12 no bus activity",
          {bus_av, bus_dten, bus_ts, bus_xts}, 0);
      return;
    end
    rem = len; k = 0;
    while (rem > 0) begin
      if (io) begin
        addr_phase(0, f_pkt0(seg, exp_tag, rem, wr), 0, 1, f_op(1, wr, rem), "R13 packet0 tag/fields");
        addr_phase(1, f_pkt1(seg, addr + 32'(4 * k)), 0, 0, f_op(1, wr, rem), "R3 packet1 beat address");
      end else begin
        addr_phase(0, addr, 1, 0, f_op(0, wr, rem), "R1 memory address");
      end
      data_phase(wr, f_be(rem));
      rem -= f_nb(rem); k++;
      if (rem > 0) chk(!done, "R2 no early done", done, 0);
    end
    if (!io) begin
      chk(done && !err, "R1 memory completion", {done, err}, 2'b10);
      return;
    end
    chk(!done && !req_ready, "R7 stalled for reply", {done, req_ready}, 0);
    for (int i = 0; i < nbad; i++) begin
      wt = exp_tag ^ 4'($urandom_range(1, 15));
      rep_valid = 1; rep_tag = wt; rep_err = $urandom_range(0, 1);
      @(negedge clk);
      rep_valid = 0;
      chk(!done && !req_ready, "R10 foreign tag ignored", {done, req_ready}, 0);
      repeat ($urandom_range(0, 2)) @(negedge clk);
    end
    rep_valid = 1; rep_tag = exp_tag; rep_err = rerr;
    @(negedge clk);
    rep_valid = 0; rep_err = 0;
    chk(done, "R7 done on matching reply", done, 1);
    chk(err == rerr, "R11 reply status", err, rerr);
    chk(req_ready, "R11 back to idle", req_ready, 1);
    exp_tag = exp_tag + 4'd1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    int len;
    bit io, wr;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R14 reset state
    chk(req_ready && !bus_av && !bus_ts && !bus_xts && !bus_dten && !ld_valid && !done && !err,
        "R14 reset state", {req_ready, bus_av, bus_ts, bus_xts, bus_dten, ld_valid, done, err},
        8'b1000_0000);
    // Directed corners
    do_req(1, 0, 24'hABC123, 32'h0001_0000, 0, 0, 0);     // R12 zero length
    do_req(1, 1, 24'hABC123, 32'h0001_0000, 129, 0, 0);   // R12 over limit
    do_req(0, 0, 24'h000000, 32'h0000_1000, 5, 0, 0);     // R12 memory too long
    do_req(0, 1, 24'h0, 32'h1234_5678, 3, 0, 0);          // R1 memory store
    do_req(0, 0, 24'h0, 32'h8765_4320, 4, 0, 0);          // R1 memory load
    do_req(1, 0, 24'h5A5A5A, 32'h000F_FFFC, 1, 0, 0);     // R3 single byte
    do_req(1, 1, 24'h123456, 32'h0000_0100, 4, 0, 1);     // R10 one foreign reply
    do_req(1, 0, 24'hFEDCBA, 32'h0000_0200, 5, 1, 2);     // R11 error reply
    do_req(1, 1, 24'h0F0F0F, 32'hC000_0000, 128, 0, 0);   // R2 max length
    do_req(1, 0, 24'hF0F0F0, 32'hC000_1000, 7, 0, 0);     // R3 remainder 3
    // Random mix
    for (int n = 0; n < 40; n++) begin
      io = ($urandom_range(0, 3) != 0);
      wr = $urandom_range(0, 1);
      if ($urandom_range(0, 9) == 0) len = ($urandom_range(0, 1) == 0) ? 0 : $urandom_range(129, 255);
      else len = io ? $urandom_range(1, 128) : $urandom_range(1, 4);
      do_req(io, wr, 24'($urandom), $urandom, len, ($urandom_range(0, 4) == 0), $urandom_range(0, 2));
      repeat ($urandom_range(0, 2)) @(negedge clk);
    end
    chk(req_ready && !done, "R6 idle at end", {req_ready, done}, 2'b10);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule